// File: doc/BRIEF.md
# ECP Reverse-Channel Receiver with Run-Length Expansion

This block is the host side of an ECP parallel link when the peripheral is sending. A read request carries a byte count. If the bus still faces forward, the block turns it around first. It then collects bytes with the reverse-channel handshake and sorts each one by the peripheral's data/command flag. It expands run-length commands into repeated bytes on a valid/ready output stream.

A separate request turns the bus back to the forward direction. A mode-exit input clears any run that is still pending. Negotiation, forward writes, channel addressing and DMA belong to other blocks. In this design one timing tick is one clock cycle.

When a read completes, the block raises a one-cycle completion pulse. The pulse carries the number of bytes it delivered and a flag that shows whether a handshake timeout ended the read.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset the block is idle and faces forward: `busDirIn`=0, `hostAckN`=1, `revReqN`=1, `strobeN`=1, `selInN`=1, `outValid`=0.
- R2: A read accepted while forward sets `busDirIn`=1 and drives `hostAckN` low on the next cycle. `revReqN` goes low SETUP_TICKS cycles later. The block then waits up to RESP_TICKS cycles for `revAckN` low; if it stays high, the read completes with `doneTimeout`=1 and count 0. A read accepted while already reversed skips this turnaround.
- R3: A byte is latched on a cycle where `periphClkN` is low. If `dataFlag`=1 it is data and appears once on the output stream. The stream is only valid while `busDirIn`=1.
- R4: A command byte (`dataFlag`=0) with bit 7 = 0 loads a run count N from bits 6:0. The next data byte is output once and then repeated N more times.
- R5: A command byte with bit 7 = 1 is discarded: it produces no output and leaves the run state unchanged.
- R6: After a command is latched, or after a data byte is accepted on the stream, `hostAckN` rises. When `periphClkN` returns high within RESP_TICKS cycles, `hostAckN` goes low again. Otherwise the read completes with `doneTimeout`=1.
- R7: Repeats stop when the request count is reached. Leftover repeats are emitted first by the next read.
- R8: While repeats are emitted, no bus handshake takes place: `hostAckN` does not change.
- R9: With `outReady` low, `outValid` stays high, `outData` stays stable and no progress is made.
- R10: If `periphClkN` stays high for IDLE_TICKS cycles while the block waits for a byte, the read completes with the bytes gathered so far and `doneTimeout`=0.
- R11: A pulse on `modeExit` clears the pending run count, the run flag and the repeat byte.
- R12: A forward request while reversed drives `revReqN` high. The block waits up to RESP_TICKS cycles for `revAckN` high, then sets `hostAckN`=1 and `busDirIn`=0 even if no response came.
- R13: A read ends with one `doneValid` cycle. `doneCount` gives the bytes delivered; a count of 0 completes at once with no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing tick |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Start a read; accepted only when idle |
| reqCount | input | CNT_W | Bytes requested by the read |
| fwdReq | input | 1 | Turn the bus back to forward; accepted when idle and reversed |
| modeExit | input | 1 | Clear the pending run-length state |
| busData | input | 8 | Data lines from the peripheral |
| periphClkN | input | 1 | Peripheral byte strobe, active low |
| dataFlag | input | 1 | 1 = data byte, 0 = command byte |
| revAckN | input | 1 | Peripheral acknowledge of a direction change |
| strobeN | output | 1 | Host strobe, held high |
| hostAckN | output | 1 | Host handshake line |
| revReqN | output | 1 | Reverse request, low while reversed |
| selInN | output | 1 | Select line, held high |
| busDirIn | output | 1 | 1 = data lines are input |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the byte |
| outData | output | 8 | Output byte |
| doneValid | output | 1 | One-cycle completion pulse |
| doneTimeout | output | 1 | Read ended on a handshake timeout |
| doneCount | output | CNT_W | Bytes delivered by the read |

## Verification
`busDirIn` and `hostAckN` change one cycle after a read is accepted, and `revReqN` falls SETUP_TICKS cycles after that. The bench samples these at the falling edges that follow those rising edges. A forward release with no response is checked at the exact edge: `busDirIn` is still high RESP_TICKS-1 cycles after the request is accepted and low one cycle later. Stream transfers are recorded just after each falling edge. `outReady` changes only at falling edges, so each recorded pair is the one accepted at the next rising edge. Completion is awaited in a bounded loop that latches the single `doneValid` cycle, and handshake activity is counted from the rises of `hostAckN`.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;

  typedef struct packed {
    logic loadReq;   // capture the request count
    logic latch;     // capture bus byte and decode a run command
    logic takeData;  // data byte accepted downstream
    logic takeRep;   // repeat byte accepted downstream
    logic clrRun;    // drop pending run state
    logic selRep;    // output mux selects the repeat byte
  } dpStrobe_t;

  typedef enum logic [3:0] {
    S_IDLE, S_REV_SETUP, S_REV_WAIT, S_LOOP, S_WAIT_BYTE,
    S_EMIT_DATA, S_ACK_HI, S_EMIT_REP, S_FWD_WAIT, S_DONE
  } ctrlState_t;

endpackage

// File: rtl/ecp_rev_dp.sv
module ecp_rev_dp
  import ecp_rev_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [7:0]       busData,
  input  logic             dataFlag,
  output logic             remZero,
  output logic             repAvail,
  output logic [7:0]       outData,
  output logic [CNT_W-1:0] doneCount
);

  localparam int RUN_W = 7;

  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] delivered;
  logic [RUN_W-1:0] runCount;
  logic             runFlag;
  logic [7:0]       repeatByte;
  logic [7:0]       latchByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining  <= '0;
      delivered  <= '0;
      runCount   <= '0;
      runFlag    <= 1'b0;
      repeatByte <= '0;
      latchByte  <= '0;
    end else begin
      if (stb.loadReq) begin
        remaining <= reqCount;
        delivered <= '0;
      end
      if (stb.latch) begin
        latchByte <= busData;
        if (!dataFlag && !busData[7]) begin
          runCount <= busData[RUN_W-1:0];
          runFlag  <= 1'b1;
        end
      end
      if (stb.takeData) begin
        remaining <= remaining - 1'b1;
        delivered <= delivered + 1'b1;
        if (runFlag) begin
          repeatByte <= latchByte;
          runFlag    <= 1'b0;
        end
      end
      if (stb.takeRep) begin
        remaining <= remaining - 1'b1;
        delivered <= delivered + 1'b1;
        runCount  <= runCount - 1'b1;
      end
      if (stb.clrRun) begin
        runCount   <= '0;
        runFlag    <= 1'b0;
        repeatByte <= '0;
      end
    end
  end

  assign remZero   = (remaining == '0);
  assign repAvail  = (runCount != '0) && !runFlag && !remZero;
  assign outData   = stb.selRep ? repeatByte : latchByte;
  assign doneCount = delivered;

  // R7: a byte is never taken once the request is satisfied
  p_rem_floor_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeData || stb.takeRep) |-> !remZero);

  // R4: each emitted repeat consumes exactly one count
  p_run_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeRep && !stb.clrRun) |=> (runCount == RUN_W'($past(runCount) - 7'd1)));

  // R5: channel-address commands leave the run state alone
  p_cmd_hi_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latch && !dataFlag && busData[7] && !stb.clrRun)
      |=> (runCount == $past(runCount)) && (runFlag == $past(runFlag)));

endmodule

// File: rtl/ecp_rev_ctrl.sv
module ecp_rev_ctrl
  import ecp_rev_pkg::*;
#(
  parameter int SETUP_TICKS = 1,
  parameter int RESP_TICKS  = 6,
  parameter int IDLE_TICKS  = 2000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqStart,
  input  logic      fwdReq,
  input  logic      modeExit,
  input  logic      periphClkN,
  input  logic      dataFlag,
  input  logic      revAckN,
  input  logic      outReady,
  input  logic      remZero,
  input  logic      repAvail,
  output dpStrobe_t stb,
  output logic      outValid,
  output logic      hostAckN,
  output logic      revReqN,
  output logic      busDirIn,
  output logic      doneValid,
  output logic      doneTimeout
);

  localparam int MAX_T = (IDLE_TICKS > RESP_TICKS) ?
                         ((IDLE_TICKS > SETUP_TICKS) ? IDLE_TICKS : SETUP_TICKS) :
                         ((RESP_TICKS > SETUP_TICKS) ? RESP_TICKS : SETUP_TICKS);
  localparam int TMR_W = $clog2(MAX_T + 1);
  localparam logic [TMR_W-1:0] SETUP_LAST = TMR_W'(SETUP_TICKS - 1);
  localparam logic [TMR_W-1:0] RESP_LAST  = TMR_W'(RESP_TICKS - 1);
  localparam logic [TMR_W-1:0] IDLE_LAST  = TMR_W'(IDLE_TICKS - 1);

  ctrlState_t       state;
  logic [TMR_W-1:0] tmr;

  always_comb begin
    stb          = '0;
    stb.clrRun   = modeExit;
    stb.loadReq  = (state == S_IDLE) && reqStart;
    stb.latch    = (state == S_WAIT_BYTE) && !periphClkN;
    stb.takeData = (state == S_EMIT_DATA) && outReady;
    stb.takeRep  = (state == S_EMIT_REP) && repAvail && outReady;
    stb.selRep   = (state == S_EMIT_REP);
  end

  assign outValid  = (state == S_EMIT_DATA) || ((state == S_EMIT_REP) && repAvail);
  assign doneValid = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      tmr         <= '0;
      hostAckN    <= 1'b1;
      revReqN     <= 1'b1;
      busDirIn    <= 1'b0;
      doneTimeout <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          tmr <= '0;
          if (reqStart) begin
            doneTimeout <= 1'b0;
            if (!busDirIn) begin
              busDirIn <= 1'b1;
              hostAckN <= 1'b0;
              state    <= S_REV_SETUP;
            end else begin
              state <= S_LOOP;
            end
          end else if (fwdReq && busDirIn) begin
            revReqN <= 1'b1;
            state   <= S_FWD_WAIT;
          end
        end
        S_REV_SETUP: begin
          if (tmr == SETUP_LAST) begin
            revReqN <= 1'b0;
            tmr     <= '0;
            state   <= S_REV_WAIT;
          end else tmr <= tmr + 1'b1;
        end
        S_REV_WAIT: begin
          if (!revAckN) begin
            tmr   <= '0;
            state <= S_LOOP;
          end else if (tmr == RESP_LAST) begin
            doneTimeout <= 1'b1;
            state       <= S_DONE;
          end else tmr <= tmr + 1'b1;
        end
        S_LOOP: begin
          tmr <= '0;
          if (remZero)       state <= S_DONE;
          else if (repAvail) state <= S_EMIT_REP;
          else               state <= S_WAIT_BYTE;
        end
        S_WAIT_BYTE: begin
          if (!periphClkN) begin
            tmr <= '0;
            if (dataFlag) state <= S_EMIT_DATA;
            else begin
              hostAckN <= 1'b1;
              state    <= S_ACK_HI;
            end
          end else if (tmr == IDLE_LAST) begin
            state <= S_DONE;
          end else tmr <= tmr + 1'b1;
        end
        S_EMIT_DATA: begin
          if (outReady) begin
            hostAckN <= 1'b1;
            tmr      <= '0;
            state    <= S_ACK_HI;
          end
        end
        S_ACK_HI: begin
          if (periphClkN) begin
            hostAckN <= 1'b0;
            state    <= S_LOOP;
          end else if (tmr == RESP_LAST) begin
            doneTimeout <= 1'b1;
            state       <= S_DONE;
          end else tmr <= tmr + 1'b1;
        end
        S_EMIT_REP: begin
          if (!repAvail) state <= S_LOOP;
        end
        S_FWD_WAIT: begin
          if (!revAckN == 1'b0 || tmr == RESP_LAST) begin
            hostAckN <= 1'b1;
            busDirIn <= 1'b0;
            tmr      <= '0;
            state    <= S_IDLE;
          end else tmr <= tmr + 1'b1;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: the bus handshake line is frozen while repeats are emitted
  p_rep_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EMIT_REP) |=> $stable(hostAckN));

  // R2: a turnaround keeps the reverse request low until the read is over
  p_rev_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_BYTE) |-> (!revReqN && busDirIn));

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rev_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SETUP_TICKS = 1,
  parameter int RESP_TICKS  = 6,
  parameter int IDLE_TICKS  = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqStart,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             fwdReq,
  input  logic             modeExit,
  input  logic [7:0]       busData,
  input  logic             periphClkN,
  input  logic             dataFlag,
  input  logic             revAckN,
  output logic             strobeN,
  output logic             hostAckN,
  output logic             revReqN,
  output logic             selInN,
  output logic             busDirIn,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             doneValid,
  output logic             doneTimeout,
  output logic [CNT_W-1:0] doneCount
);

  dpStrobe_t stb;
  logic      remZero;
  logic      repAvail;

  ecp_rev_ctrl #(
    .SETUP_TICKS(SETUP_TICKS),
    .RESP_TICKS (RESP_TICKS),
    .IDLE_TICKS (IDLE_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .fwdReq(fwdReq),
    .modeExit(modeExit), .periphClkN(periphClkN), .dataFlag(dataFlag),
    .revAckN(revAckN), .outReady(outReady), .remZero(remZero),
    .repAvail(repAvail), .stb(stb), .outValid(outValid),
    .hostAckN(hostAckN), .revReqN(revReqN), .busDirIn(busDirIn),
    .doneValid(doneValid), .doneTimeout(doneTimeout)
  );

  ecp_rev_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqCount(reqCount),
    .busData(busData), .dataFlag(dataFlag), .remZero(remZero),
    .repAvail(repAvail), .outData(outData), .doneCount(doneCount)
  );

  assign strobeN = 1'b1;
  assign selInN  = 1'b1;

  // R9: a stalled byte stays offered and unchanged
  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !modeExit) |=> (outValid && $stable(outData)));

  // R12: facing forward always leaves the host handshake line high
  p_fwd_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busDirIn |-> hostAckN);

  // R3: output bytes only exist while the bus faces the host
  p_out_rev_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busDirIn);

endmodule

// File: tb/ecp_rev_rx_bench.sv
module ecp_rev_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStart = 1'b0;
  logic [CNT_W-1:0] reqCount = '0;
  logic fwdReq = 1'b0;
  logic modeExit = 1'b0;
  logic [7:0] busData = '0;
  logic periphClkN = 1'b1;
  logic dataFlag = 1'b1;
  logic revAckN = 1'b1;
  logic strobeN, hostAckN, revReqN, selInN, busDirIn;
  logic outValid;
  logic outReady = 1'b1;
  logic [7:0] outData;
  logic doneValid, doneTimeout;
  logic [CNT_W-1:0] doneCount;

  int checks = 0;
  int failures = 0;
  logic [7:0] outLog [0:15];
  int outN = 0;
  int ackRises = 0;
  logic prevAck = 1'b1;
  bit doneSeen = 0;
  int doneCntS = 0;
  int doneToS = 0;
  bit periphAlive = 1;

  ecp_rev_rx u_ecp_rev_rx (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqCount(reqCount),
    .fwdReq(fwdReq), .modeExit(modeExit), .busData(busData),
    .periphClkN(periphClkN), .dataFlag(dataFlag), .revAckN(revAckN),
    .strobeN(strobeN), .hostAckN(hostAckN), .revReqN(revReqN),
    .selInN(selInN), .busDirIn(busDirIn), .outValid(outValid),
    .outReady(outReady), .outData(outData), .doneValid(doneValid),
    .doneTimeout(doneTimeout), .doneCount(doneCount)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // peripheral direction acknowledge follows the reverse request
  initial forever begin
    @(negedge clk);
    if (periphAlive) revAckN = revReqN;
  end

  // stream, handshake and completion monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (outValid && outReady && outN < 16) begin
      outLog[outN] = outData;
      outN++;
    end
    if (hostAckN && !prevAck) ackRises++;
    prevAck = hostAckN;
    if (doneValid) begin
      doneSeen = 1;
      doneCntS = int'(doneCount);
      doneToS  = int'(doneTimeout);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    outN = 0; ackRises = 0; doneSeen = 0;
  endtask

  task automatic startRead(input int n);
    @(negedge clk);
    reqCount = CNT_W'(n);
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
  endtask

  task automatic waitDone(input int maxc);
    for (int i = 0; i < maxc && !doneSeen; i++) @(negedge clk);
    @(negedge clk);
    chk("R13 completion pulse seen", int'(doneSeen), 1);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic isData);
    while (hostAckN !== 1'b0) @(negedge clk);
    busData = b;
    dataFlag = isData;
    periphClkN = 1'b0;
    while (hostAckN !== 1'b1) @(negedge clk);
    periphClkN = 1'b1;
  endtask

  task automatic pulseExit();
    @(negedge clk); modeExit = 1'b1;
    @(negedge clk); modeExit = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busDirIn", int'(busDirIn), 0);
    chk("R1 hostAckN", int'(hostAckN), 1);
    chk("R1 revReqN", int'(revReqN), 1);
    chk("R1 strobe/select", int'({strobeN, selInN}), 3);
    chk("R1 outValid", int'(outValid), 0);
  endtask

  task automatic t_first_read();
    clearMon();
    fork
      begin
        @(negedge clk);
        reqCount = 8'd3; reqStart = 1'b1;
        @(negedge clk);
        reqStart = 1'b0;
        chk("R2 dir in after accept", int'(busDirIn), 1);
        chk("R2 hostAckN low after accept", int'(hostAckN), 0);
        chk("R2 revReqN still high", int'(revReqN), 1);
        @(negedge clk);
        chk("R2 revReqN low after setup", int'(revReqN), 0);
      end
      begin
        sendByte(8'hA1, 1'b1); sendByte(8'hB2, 1'b1); sendByte(8'hC3, 1'b1);
      end
    join
    waitDone(100);
    chk("R13 count 3", doneCntS, 3);
    chk("R6 no timeout", doneToS, 0);
    chk("R3 bytes out", outN, 3);
    chk("R3 byte0", int'(outLog[0]), 'hA1);
    chk("R3 byte1", int'(outLog[1]), 'hB2);
    chk("R3 byte2", int'(outLog[2]), 'hC3);
    chk("R6 handshakes", ackRises, 3);
    chk("R6 hostAckN low after handshake", int'(hostAckN), 0);
  endtask

  task automatic t_cmd_skip();
    clearMon();
    fork
      startRead(1);
      begin sendByte(8'h85, 1'b0); sendByte(8'h11, 1'b1); end
    join
    waitDone(100);
    chk("R5 single output", outN, 1);
    chk("R5 data after channel cmd", int'(outLog[0]), 'h11);
    chk("R5 both handshaked", ackRises, 2);
  endtask

  task automatic t_rle();
    clearMon();
    fork
      startRead(4);
      begin sendByte(8'h03, 1'b0); sendByte(8'hAB, 1'b1); end
    join
    waitDone(100);
    chk("R4 count", doneCntS, 4);
    chk("R4 outputs", outN, 4);
    for (int i = 0; i < 4; i++) chk("R4 repeated value", int'(outLog[i]), 'hAB);
    chk("R8 two handshakes only", ackRises, 2);
  endtask

  task automatic t_carry();
    clearMon();
    fork
      startRead(3);
      begin sendByte(8'h05, 1'b0); sendByte(8'h5C, 1'b1); end
    join
    waitDone(100);
    chk("R7 first read capped", doneCntS, 3);
    clearMon();
    fork
      startRead(4);
      sendByte(8'h77, 1'b1);
    join
    waitDone(100);
    chk("R7 second read count", doneCntS, 4);
    chk("R7 carry 0", int'(outLog[0]), 'h5C);
    chk("R7 carry 2", int'(outLog[2]), 'h5C);
    chk("R7 new byte", int'(outLog[3]), 'h77);
    chk("R8 one handshake for carried repeats", ackRises, 1);
  endtask

  task automatic t_zero();
    clearMon();
    startRead(0);
    waitDone(20);
    chk("R13 zero count", doneCntS, 0);
    chk("R13 zero no handshake", ackRises, 0);
  endtask

  task automatic t_stall_exit();
    clearMon();
    outReady = 1'b0;
    fork
      startRead(5);
      begin sendByte(8'h06, 1'b0); sendByte(8'h9E, 1'b1); end
      begin
        while (!outValid) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          chk("R9 data held valid", int'(outValid), 1);
          chk("R9 data stable", int'(outData), 'h9E);
        end
        chk("R9 nothing taken", outN, 0);
        outReady = 1'b1;
        @(negedge clk);
        outReady = 1'b0;
        while (!outValid) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk("R9 repeat held", int'(outValid), 1);
        end
        chk("R9 repeat not taken", outN, 1);
        outReady = 1'b1;
      end
    join
    waitDone(100);
    chk("R9 count after stalls", doneCntS, 5);
    chk("R9 last byte", int'(outLog[4]), 'h9E);
    pulseExit();
    clearMon();
    fork
      startRead(1);
      sendByte(8'h44, 1'b1);
    join
    waitDone(100);
    chk("R11 leftover cleared", int'(outLog[0]), 'h44);
    chk("R11 bus used", ackRises, 1);
  endtask

  task automatic t_idle_timeout();
    clearMon();
    fork
      startRead(2);
      sendByte(8'h61, 1'b1);
    join
    waitDone(3000);
    chk("R10 partial count", doneCntS, 1);
    chk("R10 no timeout flag", doneToS, 0);
    chk("R10 byte", int'(outLog[0]), 'h61);
  endtask

  task automatic t_ack_timeout();
    clearMon();
    fork
      startRead(1);
      begin
        while (hostAckN !== 1'b0) @(negedge clk);
        busData = 8'h70; dataFlag = 1'b1; periphClkN = 1'b0;
      end
    join
    waitDone(100);
    chk("R6 timeout flag", doneToS, 1);
    chk("R6 delivered before timeout", doneCntS, 1);
    @(negedge clk);
    periphClkN = 1'b1;
  endtask

  task automatic t_forward();
    @(negedge clk); fwdReq = 1'b1;
    @(negedge clk); fwdReq = 1'b0;
    chk("R12 revReqN high", int'(revReqN), 1);
    chk("R12 still reversed", int'(busDirIn), 1);
    for (int i = 0; i < 3 && busDirIn; i++) @(negedge clk);
    chk("R12 dir out", int'(busDirIn), 0);
    chk("R12 hostAckN high", int'(hostAckN), 1);
  endtask

  task automatic t_rev_timeout();
    periphAlive = 0;
    revAckN = 1'b1;
    clearMon();
    startRead(1);
    waitDone(50);
    chk("R2 turnaround timeout", doneToS, 1);
    chk("R2 nothing read", doneCntS, 0);
    chk("R2 left reversed", int'(busDirIn), 1);
  endtask

  task automatic t_fwd_dead();
    revAckN = 1'b0;
    @(negedge clk); fwdReq = 1'b1;
    @(negedge clk); fwdReq = 1'b0;
    chk("R12 request raised", int'(revReqN), 1);
    repeat (5) @(negedge clk);
    chk("R12 waits full window", int'(busDirIn), 1);
    @(negedge clk);
    chk("R12 proceeds without response", int'(busDirIn), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_read();
    t_cmd_skip();
    t_rle();
    t_carry();
    t_zero();
    t_stall_exit();
    t_idle_timeout();
    t_ack_timeout();
    t_forward();
    t_rev_timeout();
    t_fwd_dead();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule